// File: doc/BRIEF.md
# PCI Bus-Master Memory Read Sequencer

This block runs memory read transactions as a PCI bus master. It starts once the bus has been granted to it and the caller has taken care of arbitration. The caller pulses `go` together with a start address, a word count, a buffer kind, a burst-enable bit, a descriptor-layout qualifier and a command-select bit. The block then places the address and command on the bus. It runs the data phases with IRDY and watches DEVSEL and TRDY from the target. Each 32-bit word is handed back with a one-cycle valid strobe. At the end the block releases the bus through a turnaround clock and pulses `done`.

The block picks non-burst or linear-burst form from the request. In non-burst form every word is its own transaction with its own address phase, and the address advances by four. In burst form there is a single address phase. FRAME stays high until the next-to-last word has been taken. The bus command depends on the buffer kind and the command-select bit. If no target claims the access within a fixed number of data clocks, the transaction stops and a sticky error flag is raised.

Bus signals appear at the ports as active-high "asserted" levels, with separate output enables for the address/data lines and for the control lines (C/BE, FRAME, IRDY). A pad wrapper outside the block inverts them to the bus's active-low form.

Top module: `pci_rd_seq`

## Requirements
- R1: While reset is held, and afterwards until a request is accepted, `busy`, `done`, `ctl_oe`, `ad_oe`, `frame_o`, `irdy_o` and `rd_valid` are all low.
- R2: A `go` pulse is accepted only when the block is idle and `go_cnt` is non-zero. A `go` with a zero count, or a `go` while busy, changes nothing on the ports.
- R3: The command driven on `cbe_o` during an address phase is 4'h6 for every non-burst read and for bursts of buffer kinds 2'b00 (init block), 2'b01 (descriptor) and 2'b11 (spare, handled as init block). For bursts of kind 2'b10 (transmit buffer) it is 4'hE when `go_cmd_sel`=0 and 4'hC when `go_cmd_sel`=1.
- R4: Burst form is used only when `go_burst_en`=1. For kind 2'b01 it also needs `go_desc_ok`=1. Otherwise the request runs as non-burst reads.
- R5: An address phase lasts one clock, with `frame_o`=1, `ad_oe`=1 and `irdy_o`=0. `ad_o` carries the current address, and in burst form bits [1:0] are forced to 00.
- R6: `irdy_o` rises in the clock right after each address phase. While it is high, `cbe_o` is 4'h0 (all byte lanes enabled) and `ad_oe` is 0.
- R7: `rd_valid` is high exactly in the data-phase clocks where `trdy_i` is high, and `rd_data` then equals `ad_i`.
- R8: In non-burst form, each word is a separate transaction. `frame_o` is low during its data phase, and the address of each transaction is 4 more than that of the one before.
- R9: In burst form, `frame_o` stays high through the data phases until the next-to-last word is taken. The last data phase runs with `frame_o`=0 and `irdy_o`=1.
- R10: After every transaction, one turnaround clock follows with `ctl_oe`=1 and `frame_o`=`irdy_o`=0. The next address phase or idle comes after it.
- R11: If `devsel_i` is low in every one of the first TMO_CLKS (default 5) data clocks of a transaction, the transaction ends at that point and all remaining words are dropped. `tmo_err` is then set and stays set until the next accepted request.
- R12: `busy` is high from the clock after a request is accepted until the final turnaround ends. `done` pulses for one clock as the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Request strobe, taken when idle |
| go_addr | input | 32 | Start byte address |
| go_cnt | input | CNT_W | Number of 32-bit words to read |
| go_kind | input | 2 | Buffer kind: 00 init, 01 descriptor, 10 transmit, 11 spare |
| go_burst_en | input | 1 | Allow burst form |
| go_desc_ok | input | 1 | Descriptor layout allows bursting |
| go_cmd_sel | input | 1 | Transmit-buffer burst command select |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| tmo_err | output | 1 | Sticky DEVSEL timeout flag |
| ad_o | output | 32 | Address out |
| ad_i | input | 32 | Read data in |
| ad_oe | output | 1 | Address/data output enable |
| cbe_o | output | 4 | Command / byte enables, asserted-high command code |
| ctl_oe | output | 1 | Enable for C/BE, FRAME and IRDY |
| frame_o | output | 1 | FRAME asserted |
| irdy_o | output | 1 | IRDY asserted |
| devsel_i | input | 1 | DEVSEL asserted by target |
| trdy_i | input | 1 | TRDY asserted by target |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 32 | Read word |

## Verification
The bound checker checks on every cycle the local bus rules:
- the command codes legal in an address phase;
- IRDY following an address phase with all lanes enabled;
- the data strobe only under an IRDY/TRDY handshake;
- the turnaround shape when IRDY falls;
- FRAME being already low in a normal last data phase;
- address alignment in burst commands;
- quiet ports while idle, and the single-clock `done`.

Only the bench's scenarios show the choices that depend on the whole request. These are which buffer kinds and settings give burst form and which command, how many address phases a request produces and how the address steps, the word order and count under target wait states, the exact data clock where a DEVSEL timeout ends a request, and requests that must be ignored.

// File: rtl/pci_rd_pkg.sv
package pci_rd_pkg;

   localparam int unsigned BUS_W     = 32;
   localparam int unsigned CMD_W     = 4;
   localparam logic [BUS_W-1:0] ADDR_STEP = 32'd4;

   // Buffer kinds as presented on go_kind
   typedef enum logic [1:0] {
      KIND_INIT  = 2'b00,
      KIND_DESC  = 2'b01,
      KIND_TXBUF = 2'b10,
      KIND_SPARE = 2'b11
   } buf_kind_e;

   // Memory read command codes
   localparam logic [CMD_W-1:0] CMD_MEM_RD  = 4'h6;
   localparam logic [CMD_W-1:0] CMD_RD_MULT = 4'hC;
   localparam logic [CMD_W-1:0] CMD_RD_LINE = 4'hE;
   localparam logic [CMD_W-1:0] BE_ALL_ON   = 4'h0;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2,
      PH_TURN = 2'd3
   } phase_e;

endpackage

// File: rtl/pci_rd_plan.sv
// Picks transaction form and bus command from the request fields.
module pci_rd_plan
   import pci_rd_pkg::*;
#(
   parameter bit ALLOW_BURST = 1'b1
) (
   input  logic [1:0]       kind,
   input  logic             burst_en,
   input  logic             desc_ok,
   input  logic             cmd_sel,
   output logic             burst,
   output logic [CMD_W-1:0] cmd
);

   generate
      if (ALLOW_BURST) begin : g_burst
         logic kind_ok;
         always_comb begin
            kind_ok = (buf_kind_e'(kind) != KIND_DESC) || desc_ok;
            burst   = burst_en && kind_ok;
            if (burst && (buf_kind_e'(kind) == KIND_TXBUF))
               cmd = cmd_sel ? CMD_RD_MULT : CMD_RD_LINE;
            else
               cmd = CMD_MEM_RD;
         end
      end else begin : g_single
         logic unused_ok;
         assign unused_ok = ^{kind, burst_en, desc_ok, cmd_sel};
         assign burst = 1'b0;
         assign cmd   = CMD_MEM_RD;
      end
   endgenerate

endmodule

// File: rtl/pci_rd_dsel_watch.sv
// Counts data clocks without a target claim; flags expiry.
module pci_rd_dsel_watch #(
   parameter int unsigned TMO_CLKS = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic active,
   input  logic devsel_i,
   output logic expire
);

   localparam int unsigned TMO_W = $clog2(TMO_CLKS + 1);

   logic [TMO_W-1:0] cnt_q;
   logic             seen_q;

   assign expire = active && !seen_q && !devsel_i &&
                   (cnt_q == TMO_W'(TMO_CLKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (clear) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (active) begin
         if (devsel_i)
            seen_q <= 1'b1;
         else if (!seen_q)
            cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/pci_rd_seq.sv
module pci_rd_seq
   import pci_rd_pkg::*;
#(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned TMO_CLKS    = 5,
   parameter bit          ALLOW_BURST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [31:0]      go_addr,
   input  logic [CNT_W-1:0] go_cnt,
   input  logic [1:0]       go_kind,
   input  logic             go_burst_en,
   input  logic             go_desc_ok,
   input  logic             go_cmd_sel,
   output logic             busy,
   output logic             done,
   output logic             tmo_err,
   output logic [31:0]      ad_o,
   input  logic [31:0]      ad_i,
   output logic             ad_oe,
   output logic [3:0]       cbe_o,
   output logic             ctl_oe,
   output logic             frame_o,
   output logic             irdy_o,
   input  logic             devsel_i,
   input  logic             trdy_i,
   output logic             rd_valid,
   output logic [31:0]      rd_data
);

   localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO_LEFT = CNT_W'(2);

   initial begin
      assert (CNT_W >= 2) else $error("pci_rd_seq: CNT_W must be at least 2");
      assert (TMO_CLKS >= 1) else $error("pci_rd_seq: TMO_CLKS must be at least 1");
   end

   phase_e           ph_q;
   logic [BUS_W-1:0] addr_q;
   logic [CNT_W-1:0] left_q;
   logic             burst_q;
   logic [CMD_W-1:0] cmd_q;
   logic             frame_q;
   logic             done_q;
   logic             err_q;

   logic             plan_burst;
   logic [CMD_W-1:0] plan_cmd;
   logic             accept;
   logic             take;
   logic             expire;

   assign accept = (ph_q == PH_IDLE) && go && (go_cnt != '0);
   assign take   = (ph_q == PH_DATA) && trdy_i;

   pci_rd_plan #(
      .ALLOW_BURST (ALLOW_BURST)
   ) u_plan (
      .kind     (go_kind),
      .burst_en (go_burst_en),
      .desc_ok  (go_desc_ok),
      .cmd_sel  (go_cmd_sel),
      .burst    (plan_burst),
      .cmd      (plan_cmd)
   );

   pci_rd_dsel_watch #(
      .TMO_CLKS (TMO_CLKS)
   ) u_watch (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (ph_q == PH_ADDR),
      .active   (ph_q == PH_DATA),
      .devsel_i (devsel_i),
      .expire   (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         addr_q  <= '0;
         left_q  <= '0;
         burst_q <= 1'b0;
         cmd_q   <= CMD_MEM_RD;
         frame_q <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (ph_q)
            PH_IDLE: begin
               if (accept) begin
                  addr_q  <= go_addr;
                  left_q  <= go_cnt;
                  burst_q <= plan_burst;
                  cmd_q   <= plan_cmd;
                  err_q   <= 1'b0;
                  ph_q    <= PH_ADDR;
               end
            end
            PH_ADDR: begin
               frame_q <= burst_q && (left_q > ONE_LEFT);
               ph_q    <= PH_DATA;
            end
            PH_DATA: begin
               if (take) begin
                  left_q <= left_q - 1'b1;
                  if (!burst_q) begin
                     addr_q <= addr_q + ADDR_STEP;
                     ph_q   <= PH_TURN;
                  end else if (left_q == ONE_LEFT) begin
                     ph_q <= PH_TURN;
                  end else if (left_q == TWO_LEFT) begin
                     frame_q <= 1'b0;
                  end
               end else if (expire) begin
                  err_q  <= 1'b1;
                  left_q <= '0;
                  ph_q   <= PH_TURN;
               end
            end
            PH_TURN: begin
               frame_q <= 1'b0;
               if (left_q != '0) begin
                  ph_q <= PH_ADDR;
               end else begin
                  ph_q   <= PH_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign busy     = (ph_q != PH_IDLE);
   assign done     = done_q;
   assign tmo_err  = err_q;
   assign ad_o     = burst_q ? {addr_q[BUS_W-1:2], 2'b00} : addr_q;
   assign ad_oe    = (ph_q == PH_ADDR);
   assign cbe_o    = (ph_q == PH_ADDR) ? cmd_q : BE_ALL_ON;
   assign ctl_oe   = (ph_q != PH_IDLE);
   assign frame_o  = (ph_q == PH_ADDR) || ((ph_q == PH_DATA) && frame_q);
   assign irdy_o   = (ph_q == PH_DATA);
   assign rd_valid = take;
   assign rd_data  = ad_i;

endmodule

// File: rtl/pci_rd_seq_chk.sv
module pci_rd_seq_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             go,
   input logic [CNT_W-1:0] go_cnt,
   input logic             busy,
   input logic             done,
   input logic             tmo_err,
   input logic [1:0]       ad_lo,
   input logic             ad_oe,
   input logic [3:0]       cbe_o,
   input logic             ctl_oe,
   input logic             frame_o,
   input logic             irdy_o,
   input logic             trdy_i,
   input logic             rd_valid
);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ctl_oe && !ad_oe && !frame_o && !irdy_o && !rd_valid));

   a_r2_zero_count_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && go && (go_cnt == '0)) |=> !busy);

   a_r3_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> ((cbe_o == 4'h6) || (cbe_o == 4'hC) || (cbe_o == 4'hE)));

   a_r5_addr_phase_shape: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> (frame_o && !irdy_o && ctl_oe));

   a_r5_burst_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (ad_oe && (cbe_o != 4'h6)) |-> (ad_lo == 2'b00));

   a_r6_irdy_follows_addr: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |=> (irdy_o && !ad_oe));

   a_r6_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      irdy_o |-> (cbe_o == 4'h0));

   a_r7_handshake: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (irdy_o && trdy_i));

   a_r9_frame_low_last: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(irdy_o) && !$rose(tmo_err)) |-> !$past(frame_o));

   a_r10_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irdy_o) |-> (ctl_oe && !frame_o && !ad_oe));

   a_r11_timeout_ends: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_err) |-> (!irdy_o && ctl_oe && !$past(rd_valid)));

   a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

bind pci_rd_seq pci_rd_seq_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .go       (go),
   .go_cnt   (go_cnt),
   .busy     (busy),
   .done     (done),
   .tmo_err  (tmo_err),
   .ad_lo    (ad_o[1:0]),
   .ad_oe    (ad_oe),
   .cbe_o    (cbe_o),
   .ctl_oe   (ctl_oe),
   .frame_o  (frame_o),
   .irdy_o   (irdy_o),
   .trdy_i   (trdy_i),
   .rd_valid (rd_valid)
);

// File: tb/pci_rd_seq_bench.sv
module pci_rd_seq_bench;

   localparam int TMO = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        go = 1'b0;
   logic [31:0] go_addr = '0;
   logic [7:0]  go_cnt = '0;
   logic [1:0]  go_kind = '0;
   logic        go_burst_en = 1'b0;
   logic        go_desc_ok = 1'b0;
   logic        go_cmd_sel = 1'b0;
   logic        busy, done, tmo_err, ad_oe, ctl_oe, frame_o, irdy_o, rd_valid;
   logic [31:0] ad_o, rd_data;
   logic [3:0]  cbe_o;
   logic [31:0] ad_i = '0;
   logic        devsel_i = 1'b0;
   logic        trdy_i = 1'b0;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   pci_rd_seq u_pci_rd_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .go_addr(go_addr), .go_cnt(go_cnt),
      .go_kind(go_kind), .go_burst_en(go_burst_en), .go_desc_ok(go_desc_ok),
      .go_cmd_sel(go_cmd_sel), .busy(busy), .done(done), .tmo_err(tmo_err),
      .ad_o(ad_o), .ad_i(ad_i), .ad_oe(ad_oe), .cbe_o(cbe_o), .ctl_oe(ctl_oe),
      .frame_o(frame_o), .irdy_o(irdy_o), .devsel_i(devsel_i), .trdy_i(trdy_i),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // ---------------- target responder ----------------
   int t_dsel_lat = 0;   // data clocks before claim
   int t_ws = 0;         // wait clocks per word
   bit t_claim = 1'b1;   // target responds at all
   int t_widx = 0;
   int t_age = 0;
   int t_gap = 0;

   always begin
      @(posedge clk); #1;
      if (irdy_o) begin
         devsel_i = t_claim && (t_age >= t_dsel_lat);
         trdy_i   = devsel_i && (t_gap >= t_ws);
         ad_i     = 32'hA500_0000 + 32'(t_widx);
         t_age++;
         if (trdy_i) begin t_gap = 0; t_widx++; end
         else t_gap++;
      end else begin
         devsel_i = 1'b0;
         trdy_i   = 1'b0;
         t_age = 0;
         t_gap = 0;
      end
   end

   // ---------------- behavioural reference ----------------
   int          m_st = 0;      // 0 idle, 1 address, 2 data, 3 turnaround
   logic [31:0] m_addr = '0;
   int          m_left = 0;
   bit          m_burst = 0;
   logic [3:0]  m_cmd = 4'h6;
   bit          m_fr = 0;
   int          m_age = 0;
   bit          m_seen = 0;
   bit          m_err = 0;
   bit          m_done = 0;

   function automatic bit ref_burst(input logic [1:0] k, input bit be, input bit dok);
      if (!be) return 1'b0;
      if (k == 2'b01) return dok;
      return 1'b1;
   endfunction

   function automatic logic [3:0] ref_cmd(input bit b, input logic [1:0] k, input bit cs);
      if (b && k == 2'b10) return cs ? 4'hC : 4'hE;
      return 4'h6;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_left = 0; m_burst = 0; m_fr = 0; m_err = 0; m_done = 0;
         m_addr = '0; m_cmd = 4'h6;
      end else begin
         m_done = 0;
         case (m_st)
            0: if (go && go_cnt != 0) begin
                  m_addr  = go_addr;
                  m_left  = int'(go_cnt);
                  m_burst = ref_burst(go_kind, go_burst_en, go_desc_ok);
                  m_cmd   = ref_cmd(m_burst, go_kind, go_cmd_sel);
                  m_err   = 0;
                  m_st    = 1;
               end
            1: begin
                  m_fr = m_burst && (m_left > 1);
                  m_age = 0; m_seen = 0;
                  m_st = 2;
               end
            2: begin
                  m_age++;
                  if (devsel_i) m_seen = 1;
                  if (trdy_i) begin
                     m_left--;
                     if (!m_burst) begin m_addr += 4; m_st = 3; end
                     else if (m_left == 0) m_st = 3;
                     else if (m_left == 1) m_fr = 0;
                  end else if (!m_seen && m_age == TMO) begin
                     m_err = 1; m_left = 0; m_st = 3;
                  end
               end
            default: begin
                  if (m_left != 0) m_st = 1;
                  else begin m_st = 0; m_done = 1; end
               end
         endcase
      end
   end

   // ---------------- per-clock comparison and observation ----------------
   int          rd_cnt = 0;
   int          n_addr = 0;
   logic [3:0]  last_cmd = '0;
   logic [31:0] first_ad = '0;
   logic [31:0] last_ad = '0;

   always @(negedge clk) begin
      chk("R12 busy", 32'(busy), 32'(m_st != 0));
      chk("R12 done", 32'(done), 32'(m_done));
      chk("R10 ctl_oe", 32'(ctl_oe), 32'(m_st != 0));
      chk("R5 ad_oe", 32'(ad_oe), 32'(m_st == 1));
      chk("R9 frame_o", 32'(frame_o), 32'((m_st == 1) || (m_st == 2 && m_fr)));
      chk("R6 irdy_o", 32'(irdy_o), 32'(m_st == 2));
      chk("R3 cbe_o", 32'(cbe_o), 32'((m_st == 1) ? m_cmd : 4'h0));
      chk("R11 tmo_err", 32'(tmo_err), 32'(m_err));
      chk("R7 rd_valid", 32'(rd_valid), 32'(m_st == 2 && trdy_i));
      if (m_st == 1)
         chk("R5 ad_o", ad_o, m_burst ? {m_addr[31:2], 2'b00} : m_addr);
      if (rd_valid) begin
         chk("R7 rd_data order", rd_data, 32'hA500_0000 + 32'(rd_cnt));
         rd_cnt++;
      end
      if (ad_oe) begin
         if (n_addr == 0) first_ad = ad_o;
         last_ad = ad_o;
         last_cmd = cbe_o;
         n_addr++;
      end
   end

   // ---------------- scenarios ----------------
   task automatic run_req(input logic [31:0] a, input int n, input logic [1:0] k,
                          input bit be, input bit dok, input bit cs, input bit poke);
      @(posedge clk); #1;
      t_widx = 0; rd_cnt = 0; n_addr = 0;
      go = 1; go_addr = a; go_cnt = 8'(n); go_kind = k;
      go_burst_en = be; go_desc_ok = dok; go_cmd_sel = cs;
      @(posedge clk); #1;
      go = 0;
      if (poke) begin
         @(posedge clk); #1;
         go = 1; go_addr = 32'hDEAD_0000; go_cnt = 8'd9;
         @(posedge clk); #1;
         go = 0;
      end
      do begin @(posedge clk); #1; end while (!done);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: quiet after reset
      chk("R1 busy after reset", 32'(busy), 32'd0);
      chk("R1 ctl_oe after reset", 32'(ctl_oe), 32'd0);
      rst_n = 1;
      repeat (2) @(posedge clk);
      #1;

      // R2: zero count ignored
      go = 1; go_cnt = 0; go_addr = 32'h40;
      @(posedge clk); #1; go = 0;
      repeat (2) @(posedge clk); #1;
      chk("R2 zero count no start", 32'(busy), 32'd0);

      // R8: non-burst transmit read, three words, go while busy ignored (R2)
      t_ws = 0; t_dsel_lat = 0; t_claim = 1;
      run_req(32'h0000_1006, 3, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R8 words", 32'(rd_cnt), 32'd3);
      chk("R8 one address phase per word", 32'(n_addr), 32'd3);
      chk("R8 address step", last_ad, 32'h0000_100E);
      chk("R3 non-burst cmd", 32'(last_cmd), 32'h6);
      chk("R2 go while busy ignored", first_ad, 32'h0000_1006);

      // R9: transmit burst, line command, wait states, aligned address
      t_ws = 1;
      run_req(32'h0000_2003, 4, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
      chk("R9 burst words", 32'(rd_cnt), 32'd4);
      chk("R9 single address phase", 32'(n_addr), 32'd1);
      chk("R3 tx burst cmd_sel=0", 32'(last_cmd), 32'hE);
      chk("R5 burst address aligned", first_ad, 32'h0000_2000);

      // R3: transmit burst, multiple command, one word
      t_ws = 0;
      run_req(32'h0000_3000, 1, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0);
      chk("R3 tx burst cmd_sel=1", 32'(last_cmd), 32'hC);
      chk("R9 one-word burst", 32'(rd_cnt), 32'd1);

      // R4: descriptor without qualifier falls back to non-burst
      run_req(32'h0000_4000, 2, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0);
      chk("R4 descriptor no qualifier phases", 32'(n_addr), 32'd2);
      chk("R4 descriptor cmd", 32'(last_cmd), 32'h6);

      // R4: descriptor with qualifier bursts, late DEVSEL
      t_dsel_lat = 2;
      run_req(32'h0000_5000, 3, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0);
      chk("R4 descriptor burst phases", 32'(n_addr), 32'd1);
      chk("R3 descriptor burst cmd", 32'(last_cmd), 32'h6);
      chk("R7 descriptor words", 32'(rd_cnt), 32'd3);

      // R3: init block burst
      t_dsel_lat = 0; t_ws = 2;
      run_req(32'h0000_6000, 2, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0);
      chk("R3 init burst cmd", 32'(last_cmd), 32'h6);
      chk("R9 init burst phases", 32'(n_addr), 32'd1);

      // R11: no target claim
      t_ws = 0; t_claim = 0;
      run_req(32'h0000_7000, 3, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R11 error raised", 32'(tmo_err), 32'd1);
      chk("R11 no words", 32'(rd_cnt), 32'd0);
      chk("R11 remaining dropped", 32'(n_addr), 32'd1);
      repeat (3) @(posedge clk); #1;
      chk("R11 error sticky", 32'(tmo_err), 32'd1);

      // R11: claim on the last allowed clock, error cleared by new request
      t_claim = 1; t_dsel_lat = TMO - 1;
      run_req(32'h0000_8000, 2, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
      chk("R11 late claim no error", 32'(tmo_err), 32'd0);
      chk("R11 late claim words", 32'(rd_cnt), 32'd2);

      // R11: timeout in burst form
      t_claim = 0;
      run_req(32'h0000_9000, 4, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
      chk("R11 burst timeout", 32'(tmo_err), 32'd1);

      repeat (4) @(posedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_err++;
      $display("FAIL R12 watchdog: done actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule